// File: doc/BRIEF.md
# Segmented Paged Address Translator

This block turns a 24-bit logical address into a physical address through two steps: a per-segment entry held in registers, then a page table entry fetched from memory. The top bits of the logical address select one of sixteen segment entries. Each entry holds the physical base address of that segment's page table, the number of valid page table entries (the bound), and a read right and a write right. The next field is a page number. The translator checks the page number against the bound and checks the access kind against the rights. Only when both checks pass does it issue a single read of the page table entry. It then returns the frame number joined to the unchanged page offset, or a 2-bit fault code.

Requests arrive with a valid/ready handshake and are taken one at a time. Each accepted request produces exactly one response pulse. Software reloads the segment entries through a write port, for example when switching address spaces. The page table entry read uses a plain synchronous memory port: data returns on the edge after the read enable.

Top module: `seg_page_xlat`

## Requirements
- R1: The logical address is split into a segment index in bits [23:20], a page number in bits [19:12] and an offset in bits [11:0]. A successful translation returns fault code 00 and a physical address equal to the entry's frame number followed by the unchanged 12-bit offset.
- R2: A pulse on the configuration write enable loads the addressed segment entry with a new base, bound, read right and write right. Requests accepted at any later edge use the new values.
- R3: A page number greater than or equal to the segment's bound gives fault code 01. A bound of zero faults on every page. A bound of 256 admits page 255.
- R4: A read to a segment whose read right is clear, or a write to a segment whose write right is clear, gives fault code 10. When a request fails both the bound check and the rights check, code 01 is reported.
- R5: A request that passes both checks issues exactly one memory read, at address base + 4 × page number.
- R6: A request that fails the bound check or the rights check issues no memory read.
- R7: The page table entry's bit 31 is its present bit and bits [11:0] are its frame number. A fetched entry with bit 31 clear gives fault code 11 and a physical address of zero.
- R8: Count the acceptance edge as edge 0. For a check fault, rsp_valid is high for one cycle, between edges 1 and 2. After an entry fetch, rsp_valid is high for one cycle, between edges 2 and 3. req_ready is low from edge 0 until the response is raised. Exactly one response follows each accepted request.
- R9: After reset, req_ready is high, rsp_valid and mem_rd_en are low, and every segment entry has bound zero, so every request faults with code 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Segment entry write enable |
| cfg_seg | input | 4 | Segment entry index to write |
| cfg_base | input | 24 | Page table physical base address |
| cfg_bound | input | 9 | Number of valid page table entries (0..256) |
| cfg_rd_ok | input | 1 | Read right |
| cfg_wr_ok | input | 1 | Write right |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Translator idle and able to accept |
| req_addr | input | 24 | Logical address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| mem_rd_en | output | 1 | Page table entry read enable |
| mem_rd_addr | output | 24 | Page table entry byte address |
| mem_rd_data | input | 32 | Entry data, valid on the edge after mem_rd_en |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 24 | Physical address (zero on a fault) |
| rsp_fault | output | 2 | 00 ok, 01 bound, 10 rights, 11 not present |

## Verification
The bench builds the block with its default parameters: a 4-bit segment index, an 8-bit page number, a 12-bit offset and frame, and a 9-bit bound. With a 9-bit bound the bench can load a full 256-entry table and confirm that page 255 translates while pages at and above a smaller bound fault. Sixteen segments give enough entries to hold distinct rights patterns side by side, along with a segment left at bound zero after reset. Page table bases below 4 KiB let a 1024-word bench memory hold every entry the tests reach, including the last entry of the full table.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_BOUND  = 2'b01,
        FLT_PROT   = 2'b10,
        FLT_ABSENT = 2'b11
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_CHECK = 2'b01,
        ST_FETCH = 2'b10
    } xlat_st_e;

endpackage

// File: rtl/seg_regs.sv
module seg_regs #(
    parameter int SEG_W  = 4,
    parameter int BASE_W = 24,
    parameter int BND_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_idx,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [BND_W-1:0]  wr_bnd,
    input  logic              wr_rd,
    input  logic              wr_wr,
    input  logic [SEG_W-1:0]  rd_idx,
    output logic [BASE_W-1:0] rd_base,
    output logic [BND_W-1:0]  rd_bnd,
    output logic              rd_rd,
    output logic              rd_wr
);
    localparam int NSEG = 1 << SEG_W;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [BND_W-1:0]  bnd;
        logic              rd;
        logic              wr;
    } seg_ent_t;

    seg_ent_t [NSEG-1:0] tbl_d;
    seg_ent_t [NSEG-1:0] tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < NSEG; i++) begin
            if (wr_en && (wr_idx == SEG_W'(i))) begin
                tbl_d[i].base = wr_base;
                tbl_d[i].bnd  = wr_bnd;
                tbl_d[i].rd   = wr_rd;
                tbl_d[i].wr   = wr_wr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign rd_base = tbl_q[rd_idx].base;
    assign rd_bnd  = tbl_q[rd_idx].bnd;
    assign rd_rd   = tbl_q[rd_idx].rd;
    assign rd_wr   = tbl_q[rd_idx].wr;

endmodule

// File: rtl/seg_check.sv
module seg_check
    import xlat_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int BND_W  = 9
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [BND_W-1:0]  bnd,
    input  logic              rd_ok,
    input  logic              wr_ok,
    input  logic              is_write,
    output fault_e            fault
);
    logic out_of_bounds;
    logic no_right;

    assign out_of_bounds = (BND_W'(page) >= bnd);
    assign no_right      = is_write ? !wr_ok : !rd_ok;

    // bound fault takes priority over a rights fault (R4)
    always_comb begin
        if (out_of_bounds)  fault = FLT_BOUND;
        else if (no_right)  fault = FLT_PROT;
        else                fault = FLT_NONE;
    end

endmodule

// File: rtl/pte_eval.sv
module pte_eval
    import xlat_pkg::*;
#(
    parameter int PTE_W   = 32,
    parameter int FRAME_W = 12
) (
    input  logic [PTE_W-1:0]   pte,
    output logic [FRAME_W-1:0] frame,
    output fault_e             fault
);
    assign frame = pte[FRAME_W-1:0];
    assign fault = pte[PTE_W-1] ? FLT_NONE : FLT_ABSENT;

endmodule

// File: rtl/seg_page_xlat.sv
module seg_page_xlat
    import xlat_pkg::*;
#(
    parameter int SEG_W   = 4,
    parameter int PAGE_W  = 8,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 12,
    parameter int PTB_W   = 24,
    parameter int PTE_W   = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [SEG_W-1:0]                  cfg_seg,
    input  logic [PTB_W-1:0]                  cfg_base,
    input  logic [PAGE_W:0]                   cfg_bound,
    input  logic                              cfg_rd_ok,
    input  logic                              cfg_wr_ok,
    input  logic                              req_valid,
    output logic                              req_ready,
    input  logic [SEG_W+PAGE_W+OFF_W-1:0]     req_addr,
    input  logic                              req_write,
    output logic                              mem_rd_en,
    output logic [PTB_W-1:0]                  mem_rd_addr,
    input  logic [PTE_W-1:0]                  mem_rd_data,
    output logic                              rsp_valid,
    output logic [FRAME_W+OFF_W-1:0]          rsp_paddr,
    output logic [1:0]                        rsp_fault
);
    localparam int VA_W  = SEG_W + PAGE_W + OFF_W;
    localparam int PA_W  = FRAME_W + OFF_W;
    localparam int BND_W = PAGE_W + 1;
    localparam int PAD_W = PTB_W - PAGE_W - 2;

    typedef struct packed {
        xlat_st_e          st;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
        logic              wr;
        logic [PTB_W-1:0]  base;
        logic [BND_W-1:0]  bnd;
        logic              rd_ok;
        logic              wr_ok;
        logic              rsp_v;
        fault_e            flt;
        logic [PA_W-1:0]   pa;
    } xlat_state_t;

    xlat_state_t s_d, s_q;

    logic [PTB_W-1:0]   seg_base;
    logic [BND_W-1:0]   seg_bnd;
    logic               seg_rd, seg_wr;
    fault_e             chk_fault;
    fault_e             pte_fault;
    logic [FRAME_W-1:0] pte_frame;
    logic               rd_en_d;

    seg_regs #(.SEG_W(SEG_W), .BASE_W(PTB_W), .BND_W(BND_W)) u_seg_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_seg),
        .wr_base (cfg_base),
        .wr_bnd  (cfg_bound),
        .wr_rd   (cfg_rd_ok),
        .wr_wr   (cfg_wr_ok),
        .rd_idx  (req_addr[VA_W-1 -: SEG_W]),
        .rd_base (seg_base),
        .rd_bnd  (seg_bnd),
        .rd_rd   (seg_rd),
        .rd_wr   (seg_wr)
    );

    seg_check #(.PAGE_W(PAGE_W), .BND_W(BND_W)) u_seg_check (
        .page     (s_q.page),
        .bnd      (s_q.bnd),
        .rd_ok    (s_q.rd_ok),
        .wr_ok    (s_q.wr_ok),
        .is_write (s_q.wr),
        .fault    (chk_fault)
    );

    pte_eval #(.PTE_W(PTE_W), .FRAME_W(FRAME_W)) u_pte_eval (
        .pte   (mem_rd_data),
        .frame (pte_frame),
        .fault (pte_fault)
    );

    always_comb begin
        s_d       = s_q;
        s_d.rsp_v = 1'b0;
        rd_en_d   = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.page  = req_addr[OFF_W +: PAGE_W];
                    s_d.off   = req_addr[OFF_W-1:0];
                    s_d.wr    = req_write;
                    s_d.base  = seg_base;
                    s_d.bnd   = seg_bnd;
                    s_d.rd_ok = seg_rd;
                    s_d.wr_ok = seg_wr;
                    s_d.st    = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (chk_fault != FLT_NONE) begin
                    s_d.rsp_v = 1'b1;
                    s_d.flt   = chk_fault;
                    s_d.pa    = '0;
                    s_d.st    = ST_IDLE;
                end else begin
                    rd_en_d   = 1'b1;
                    s_d.st    = ST_FETCH;
                end
            end
            ST_FETCH: begin
                s_d.rsp_v = 1'b1;
                s_d.flt   = pte_fault;
                s_d.pa    = (pte_fault == FLT_NONE) ? {pte_frame, s_q.off} : '0;
                s_d.st    = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready   = (s_q.st == ST_IDLE);
    assign mem_rd_en   = rd_en_d;
    assign mem_rd_addr = s_q.base + {{PAD_W{1'b0}}, s_q.page, 2'b00};
    assign rsp_valid   = s_q.rsp_v;
    assign rsp_paddr   = s_q.pa;
    assign rsp_fault   = s_q.flt;

    // R6: a bound or rights fault is never preceded by a memory read
    a_r6_no_read_on_check_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_fault == FLT_BOUND || rsp_fault == FLT_PROT)) |-> !$past(mem_rd_en));

    // R8: check faults answer two edges after acceptance
    a_r8_fault_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_fault == FLT_BOUND || rsp_fault == FLT_PROT))
            |-> $past(req_valid && req_ready, 2));

    // R8: a fetch is followed by a response one cycle later
    a_r8_fetch_then_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> ##1 rsp_valid);

    // R8: the translator is busy while a read is outstanding, response is a single pulse
    a_r8_busy_during_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !req_ready);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R1: a good translation keeps the offset of the accepted address
    a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_NONE)
            |-> ($past(req_valid && req_ready, 3)
                 && rsp_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0], 3)));

    // R7: a not-present fault returns a zero address
    a_r7_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_ABSENT) |-> (rsp_paddr == '0));

endmodule

// File: tb/seg_page_xlat_tb_top.sv
`timescale 1ns/1ps
module seg_page_xlat_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_seg;
    logic [23:0] cfg_base;
    logic [8:0]  cfg_bound;
    logic        cfg_rd_ok, cfg_wr_ok;
    logic        req_valid, req_ready, req_write;
    logic [23:0] req_addr;
    logic        mem_rd_en;
    logic [23:0] mem_rd_addr;
    logic [31:0] mem_rd_data;
    logic        rsp_valid;
    logic [23:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    int checks   = 0;
    int failures = 0;

    logic [31:0] mem [0:1023];

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[11:2]];
    end

    seg_page_xlat dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_seg(cfg_seg), .cfg_base(cfg_base), .cfg_bound(cfg_bound),
        .cfg_rd_ok(cfg_rd_ok), .cfg_wr_ok(cfg_wr_ok),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pte(input bit present, input logic [11:0] frame);
        return {present, 19'd0, frame};
    endfunction

    task automatic load_seg(input logic [3:0] s, input logic [23:0] b, input logic [8:0] bnd,
                            input bit r, input bit w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_seg = s; cfg_base = b; cfg_bound = bnd; cfg_rd_ok = r; cfg_wr_ok = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // one request; observes read enable, response and ready at negedges after acceptance
    task automatic do_req(input logic [23:0] a, input bit w,
                          output int lat, output int nresp, output bit rd_seen, output int nrd,
                          output logic [23:0] rda, output logic [23:0] pa, output logic [1:0] fl,
                          output bit busy_ok);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0; nresp = 0; rd_seen = 0; nrd = 0; rda = '0; pa = '0; fl = '0; busy_ok = 1;
        for (int i = 1; i <= 6; i++) begin
            if (i > 1) @(negedge clk);
            if (mem_rd_en) begin rd_seen = 1; nrd++; rda = mem_rd_addr; end
            if (rsp_valid) begin
                nresp++;
                if (lat == 0) begin lat = i; pa = rsp_paddr; fl = rsp_fault; end
            end
            if (lat == 0 && req_ready) busy_ok = 0;
        end
    endtask

    int lat, nresp, nrd;
    bit rd_seen, busy_ok;
    logic [23:0] rda, pa;
    logic [1:0]  fl;

    task automatic t_reset;
        check(req_ready == 1'b1, "R9 ready after reset", 32'(req_ready), 1);
        check(rsp_valid == 1'b0, "R9 rsp_valid after reset", 32'(rsp_valid), 0);
        check(mem_rd_en == 1'b0, "R9 mem_rd_en after reset", 32'(mem_rd_en), 0);
        do_req(24'h000123, 1'b0, lat, nresp, rd_seen, nrd, rda, pa, fl, busy_ok);
        check(fl == 2'b01, "R9 unloaded segment faults bound", 32'(fl), 1);
        check(!rd_seen, "R6 no read on reset fault", 32'(rd_seen), 0);
    endtask

    task automatic t_translate;
        load_seg(4'd2, 24'h000100, 9'h014, 1'b1, 1'b1);
        mem[(12'h100 + 12'd12) >> 2] = pte(1'b1, 12'hABC);
        do_req(24'h2035A7, 1'b0, lat, nresp, rd_seen, nrd, rda, pa, fl, busy_ok);
        check(fl == 2'b00, "R1 ok fault code", 32'(fl), 0);
        check(pa == 24'hABC5A7, "R1 physical address", 32'(pa), 32'hABC5A7);
        check(rda == 24'h00010C, "R5 fetch address", 32'(rda), 32'h10C);
        check(nrd == 1, "R5 single read", 32'(nrd), 1);
        check(lat == 3, "R8 fetch latency", 32'(lat), 3);
        check(nresp == 1, "R8 one response", 32'(nresp), 1);
        check(busy_ok, "R8 ready low while busy", 32'(busy_ok), 1);
        // a write with both rights passes as well
        do_req(24'h203FFF, 1'b1, lat, nresp, rd_seen, nrd, rda, pa, fl, busy_ok);
        check(pa == 24'hABCFFF && fl == 2'b00, "R1 write translation", 32'(pa), 32'hABCFFF);
    endtask

    task automatic t_bounds;
        mem[(12'h100 + 12'h13 * 4) >> 2] = pte(1'b1, 12'h055);
        do_req(24'h213000, 1'b0, lat, nresp, rd_seen, nrd, rda, pa, fl, busy_ok);
        check(fl == 2'b00 && pa == 24'h055000, "R3 last page below bound", 32'(pa), 32'h055000);
        do_req(24'h214010, 1'b0, lat, nresp, rd_seen, nrd, rda, pa, fl, busy_ok);
        check(fl == 2'b01, "R3 page equal to bound faults", 32'(fl), 1);
        check(!rd_seen, "R6 no read on bound fault", 32'(rd_seen), 0);
        check(lat == 2, "R8 check fault latency", 32'(lat), 2);
        check(nresp == 1 && busy_ok, "R8 one fault response", 32'(nresp), 1);
        load_seg(4'd6, 24'h000200, 9'h000, 1'b1, 1'b1);
        do_req(24'h600000, 1'b0, lat, nresp, rd_seen, nrd, rda, pa, fl, busy_ok);
        check(fl == 2'b01 && !rd_seen, "R3 bound zero faults", 32'(fl), 1);
        load_seg(4'd5, 24'h000800, 9'h100, 1'b1, 1'b0);
        mem[(12'h800 + 12'd1020) >> 2] = pte(1'b1, 12'hFED);
        do_req(24'h5FF00C, 1'b0, lat, nresp, rd_seen, nrd, rda, pa, fl, busy_ok);
        check(fl == 2'b00 && pa == 24'hFED00C, "R3 full table page 255", 32'(pa), 32'hFED00C);
        check(rda == 24'h000BFC, "R5 fetch address last entry", 32'(rda), 32'hBFC);
    endtask

    task automatic t_prot;
        load_seg(4'd3, 24'h000400, 9'h010, 1'b1, 1'b0);
        load_seg(4'd4, 24'h000400, 9'h010, 1'b0, 1'b1);
        mem[12'h400 >> 2] = pte(1'b1, 12'h777);
        do_req(24'h300004, 1'b1, lat, nresp, rd_seen, nrd, rda, pa, fl, busy_ok);
        check(fl == 2'b10 && !rd_seen, "R4 write without right", 32'(fl), 2);
        do_req(24'h400004, 1'b0, lat, nresp, rd_seen, nrd, rda, pa, fl, busy_ok);
        check(fl == 2'b10 && !rd_seen, "R4 read without right", 32'(fl), 2);
        check(pa == 24'h0, "R4 zero address on fault", 32'(pa), 0);
        do_req(24'h400004, 1'b1, lat, nresp, rd_seen, nrd, rda, pa, fl, busy_ok);
        check(fl == 2'b00 && pa == 24'h777004, "R4 write with right", 32'(pa), 32'h777004);
        do_req(24'h320000, 1'b1, lat, nresp, rd_seen, nrd, rda, pa, fl, busy_ok);
        check(fl == 2'b01, "R4 bound beats rights", 32'(fl), 1);
    endtask

    task automatic t_absent;
        mem[(12'h100 + 12'd20) >> 2] = pte(1'b0, 12'h321);
        do_req(24'h205111, 1'b0, lat, nresp, rd_seen, nrd, rda, pa, fl, busy_ok);
        check(fl == 2'b11, "R7 not present fault", 32'(fl), 3);
        check(pa == 24'h0, "R7 zero address", 32'(pa), 0);
        check(rd_seen && lat == 3, "R7 entry was fetched", 32'(lat), 3);
    endtask

    task automatic t_reload;
        load_seg(4'd2, 24'h000600, 9'h004, 1'b1, 1'b1);
        mem[(12'h600 + 12'd12) >> 2] = pte(1'b1, 12'h0E1);
        do_req(24'h203222, 1'b0, lat, nresp, rd_seen, nrd, rda, pa, fl, busy_ok);
        check(rda == 24'h00060C, "R2 new base used", 32'(rda), 32'h60C);
        check(pa == 24'h0E1222, "R2 new translation", 32'(pa), 32'h0E1222);
        do_req(24'h204000, 1'b0, lat, nresp, rd_seen, nrd, rda, pa, fl, busy_ok);
        check(fl == 2'b01, "R2 new bound used", 32'(fl), 1);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_seg = '0; cfg_base = '0; cfg_bound = '0;
        cfg_rd_ok = 1'b0; cfg_wr_ok = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_translate();
        t_bounds();
        t_prot();
        t_absent();
        t_reload();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule